// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps a multiplexed-address dynamic RAM alive. After reset it holds the row strobe and both byte-lane column strobes inactive for a settling wait derived from the clock frequency. It then runs a fixed number of wake-up refresh cycles of the column-before-row kind. During these cycles the device's internal row counter supplies the row, so no address is driven and the data bus is left alone. When the last wake-up cycle ends it raises `init_done` and begins periodic refresh.

In normal operation a reloadable timer schedules one refresh every retention period divided by the row count. Each scheduled refresh is added to a saturating backlog. While the backlog is non-zero, or a cycle is still in progress, the block raises `req` toward the access controller. Refresh cycles are issued only when `grant` is high. All pending refreshes are issued back to back until the backlog is empty, and then `req` falls. If `grant` is withdrawn, the cycle already in flight finishes and the rest stay pending. The cycle phase lengths are computed from nanosecond timing parameters and the clock frequency.

Top module: `dram_refresh_seq`

## Requirements
- R1: For at least `SETTLE_US*CLK_MHZ` clocks after reset is released, `ras_n`, `cas_lo_n` and `cas_hi_n` stay high. During reset, `req`, `busy` and `init_done` are low.
- R2: After the settling wait, the first wake-up cycle begins within 3 clocks. Exactly `WAKE_CYCLES` row-strobe pulses (8 by default) occur before `init_done` rises.
- R3: `req` is never high while `init_done` is low.
- R4: In every refresh cycle, both column strobes fall together. They are low for at least ceil(5 ns × CLK_MHZ / 1000) sampled clocks before `ras_n` falls.
- R5: Every `ras_n` low pulse lasts at least ceil(25 ns) clocks. The column strobes stay low for at least ceil(7 ns) clocks counted from the `ras_n` fall. `ras_n` stays high for at least ceil(15 ns) clocks between pulses.
- R6: After `init_done` rises, `req` rises `floor(RETAIN_US*CLK_MHZ/ROWS)` clocks later (within ±2) when no refresh is pending.
- R7: After initialisation, a refresh cycle starts only if `grant` was high. With `grant` low, no new strobe activity occurs.
- R8: Under `grant`, pending refreshes run back to back, with at most 2 idle clocks between cycles. `req` falls once the backlog is empty and the last cycle has finished.
- R9: The backlog saturates at `MAX_BACKLOG` (default 4). Scheduling ticks that arrive while the backlog is full are dropped.
- R10: `busy` is high whenever any strobe is low.
- R11: If `grant` falls during a cycle, that cycle completes. No further cycle starts, and `req` stays high while refreshes remain pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency `CLK_MHZ` |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Access controller hands the DRAM bus to the sequencer |
| req | output | 1 | Refresh pending or in progress; asks for the bus |
| busy | output | 1 | A refresh cycle is driving the strobes |
| init_done | output | 1 | Power-up sequence complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_lo_n | output | 1 | Lower byte column strobe, active low |
| cas_hi_n | output | 1 | Upper byte column strobe, active low |

## Verification
The assertions assume the access controller gives `grant` only in answer to `req` and never needs the bus while `busy` is high. They also assume `grant` is low until `init_done`. The stimulus keeps to these assumptions: `grant` is raised only after `req` is seen, and it is dropped either after `req` falls or deliberately in the middle of a cycle to test R11. Strobe timing is measured at the ports in clock counts that the bench derives from the nanosecond limits.

// File: rtl/drfs_pkg.sv
package drfs_pkg;
  typedef enum logic [1:0] {SQ_SETTLE, SQ_WAKE, SQ_RUN} seq_state_t;
  typedef enum logic [1:0] {PH_IDLE, PH_CSU, PH_RASLO, PH_PRE} cbr_phase_t;

  // Round a nanosecond limit up to whole clocks, never below one clock.
  function automatic int unsigned ns_to_clk(int unsigned ns, int unsigned mhz);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Precharge stretched so that the whole cycle meets the random cycle time.
  function automatic int unsigned pre_clk(int unsigned rp, int unsigned rc,
                                          int unsigned csu, int unsigned ras);
    int unsigned rest;
    rest = (rc > csu + ras) ? rc - csu - ras : 0;
    return max2(rp, rest);
  endfunction

  function automatic int unsigned interval_clk(int unsigned retain_us,
                                               int unsigned mhz, int unsigned rows);
    return (retain_us * mhz) / rows;
  endfunction
endpackage

// File: rtl/drfs_tick.sv
module drfs_tick #(
  parameter int unsigned PERIOD = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= CW'(PERIOD - 1);
    else if (!en)             cnt <= CW'(PERIOD - 1);
    else if (cnt == '0)       cnt <= CW'(PERIOD - 1);
    else                      cnt <= cnt - 1'b1;
  end

  assign tick = en && (cnt == '0);
endmodule

// File: rtl/drfs_cbr_engine.sv
module drfs_cbr_engine import drfs_pkg::*; #(
  parameter int unsigned CSU_CLK  = 1,
  parameter int unsigned RAS_CLK  = 2,
  parameter int unsigned HOLD_CLK = 1,
  parameter int unsigned PRE_CLK  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic active,
  output logic done
);
  localparam int unsigned LONGEST = max2(max2(CSU_CLK, RAS_CLK), PRE_CLK);
  localparam int unsigned CW = $clog2(LONGEST + 1);

  cbr_phase_t    phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;
  logic          phase_end;

  always_comb begin
    unique case (phase)
      PH_CSU:   last_cnt = CW'(CSU_CLK - 1);
      PH_RASLO: last_cnt = CW'(RAS_CLK - 1);
      PH_PRE:   last_cnt = CW'(PRE_CLK - 1);
      default:  last_cnt = '0;
    endcase
  end

  assign phase_end = (phase != PH_IDLE) && (cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      cnt <= '0;
      if (start) phase <= PH_CSU;
    end else if (phase_end) begin
      cnt <= '0;
      unique case (phase)
        PH_CSU:   phase <= PH_RASLO;
        PH_RASLO: phase <= PH_PRE;
        default:  phase <= PH_IDLE;
      endcase
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ras_n  = (phase != PH_RASLO);
  assign cas_n  = !((phase == PH_CSU) || ((phase == PH_RASLO) && (cnt < CW'(HOLD_CLK))));
  assign active = (phase != PH_IDLE);
  assign done   = (phase == PH_PRE) && phase_end;

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R4
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq import drfs_pkg::*; #(
  parameter int unsigned CLK_MHZ     = 50,
  parameter int unsigned SETTLE_US   = 200,
  parameter int unsigned WAKE_CYCLES = 8,
  parameter int unsigned RETAIN_US   = 8000,
  parameter int unsigned ROWS        = 512,
  parameter int unsigned MAX_BACKLOG = 4,
  parameter int unsigned T_CSR_NS    = 5,
  parameter int unsigned T_CHR_NS    = 7,
  parameter int unsigned T_RAS_NS    = 25,
  parameter int unsigned T_RP_NS     = 15,
  parameter int unsigned T_RC_NS     = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic req,
  output logic busy,
  output logic init_done,
  output logic ras_n,
  output logic cas_lo_n,
  output logic cas_hi_n
);
  localparam int unsigned C_CSU    = ns_to_clk(T_CSR_NS, CLK_MHZ);
  localparam int unsigned C_HOLD   = ns_to_clk(T_CHR_NS, CLK_MHZ);
  localparam int unsigned C_RAS    = max2(ns_to_clk(T_RAS_NS, CLK_MHZ), C_HOLD);
  localparam int unsigned C_PRE    = pre_clk(ns_to_clk(T_RP_NS, CLK_MHZ),
                                             ns_to_clk(T_RC_NS, CLK_MHZ), C_CSU, C_RAS);
  localparam int unsigned C_SETTLE = SETTLE_US * CLK_MHZ;
  localparam int unsigned C_PERIOD = interval_clk(RETAIN_US, CLK_MHZ, ROWS);
  localparam int unsigned SW       = $clog2(C_SETTLE + 1);
  localparam int unsigned WW       = $clog2(WAKE_CYCLES + 1);
  localparam int unsigned BW       = $clog2(MAX_BACKLOG + 1);

  seq_state_t    state;
  logic [SW-1:0] settle_cnt;
  logic [WW-1:0] wake_cnt;
  logic [BW-1:0] backlog;

  // Named internal events
  logic eng_start, eng_done, eng_active, eng_ras_n, eng_cas_n;
  logic sched_tick, run_start, wake_start, backlog_full;

  drfs_tick #(.PERIOD(C_PERIOD)) i_tick (
    .clk(clk), .rst_n(rst_n), .en(state == SQ_RUN), .tick(sched_tick)
  );

  drfs_cbr_engine #(.CSU_CLK(C_CSU), .RAS_CLK(C_RAS), .HOLD_CLK(C_HOLD), .PRE_CLK(C_PRE)) i_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start),
    .ras_n(eng_ras_n), .cas_n(eng_cas_n), .active(eng_active), .done(eng_done)
  );

  assign backlog_full = (backlog == BW'(MAX_BACKLOG));
  assign wake_start   = (state == SQ_WAKE) && !eng_active;
  assign run_start    = (state == SQ_RUN) && grant && !eng_active && (backlog != '0);
  assign eng_start    = wake_start || run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_SETTLE;
      settle_cnt <= '0;
      wake_cnt   <= '0;
    end else begin
      unique case (state)
        SQ_SETTLE: begin
          if (settle_cnt == SW'(C_SETTLE - 1)) state <= SQ_WAKE;
          else                                 settle_cnt <= settle_cnt + 1'b1;
        end
        SQ_WAKE: begin
          if (eng_done) begin
            wake_cnt <= wake_cnt + 1'b1;
            if (wake_cnt == WW'(WAKE_CYCLES - 1)) state <= SQ_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   backlog <= '0;
    else if (sched_tick && !run_start && !backlog_full) backlog <= backlog + 1'b1;
    else if (run_start && !sched_tick)            backlog <= backlog - 1'b1;
  end

  assign init_done = (state == SQ_RUN);
  assign req       = init_done && ((backlog != '0) || eng_active);
  assign busy      = eng_active;
  assign ras_n     = eng_ras_n;
  assign cas_lo_n  = eng_cas_n;
  assign cas_hi_n  = eng_cas_n;

  AST_QUIET_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_SETTLE) |-> (ras_n && cas_lo_n && cas_hi_n)); // R1
  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req); // R3
  AST_GRANTED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && $fell(cas_lo_n)) |-> $past(grant)); // R7
  AST_BACKLOG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    backlog <= BW'(MAX_BACKLOG)); // R9
  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_lo_n || !cas_hi_n) |-> busy); // R10
endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int MHZ    = 50;
  localparam int SETTLE = 200 * MHZ;
  localparam int WAKE   = 8;
  localparam int INTV   = (8000 * MHZ) / 512;
  localparam int MAXB   = 4;
  localparam int CSR_C  = (5 * MHZ + 999) / 1000;
  localparam int CHR_C  = (7 * MHZ + 999) / 1000;
  localparam int RAS_C  = (25 * MHZ + 999) / 1000;
  localparam int RP_C   = (15 * MHZ + 999) / 1000;
  localparam int CYC_C  = 4;

  logic clk = 0, rst_n = 0, grant = 0;
  logic req, busy, init_done, ras_n, cas_lo_n, cas_hi_n;
  int total = 0, bad = 0, pulses = 0;
  bit r3_seen = 0, finished = 0;
  int cas_lead = 0, ras_low = 0, cas_after = 0, ras_high = 0;
  logic p_ras = 1;

  always #10 clk = ~clk;

  dram_refresh_seq i_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .busy(busy),
    .init_done(init_done), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // Port monitor: strobe timing per pulse, sampled on falling clock edges
  always @(negedge clk) if (rst_n) begin
    if (req && !init_done) r3_seen = 1;
    if (p_ras && !ras_n) begin
      chk(cas_lead >= CSR_C, "R4 cas lead", cas_lead, CSR_C);
      chk(cas_lo_n == cas_hi_n, "R4 lanes", cas_hi_n, cas_lo_n);
      chk(busy, "R10 busy", busy, 1);
      if (pulses > 0) chk(ras_high >= RP_C, "R5 precharge", ras_high, RP_C);
      ras_low = 0; cas_after = 0;
    end
    if (!p_ras && ras_n) begin
      chk(ras_low >= RAS_C, "R5 ras low", ras_low, RAS_C);
      chk(cas_after >= CHR_C, "R5 cas hold", cas_after, CHR_C);
      pulses++;
      ras_high = 0;
    end
    if (!ras_n) begin
      ras_low++;
      if (!cas_lo_n) cas_after++;
    end else begin
      ras_high++;
      cas_lead = cas_lo_n ? 0 : cas_lead + 1;
    end
    p_ras = ras_n;
  end

  task automatic t_reset();
    grant = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_lo_n && cas_hi_n, "R1 strobes in reset", ras_n, 1);
    chk(!req && !busy && !init_done, "R1 flags in reset", req | busy | init_done, 0);
    rst_n = 1;
  endtask

  task automatic t_powerup();
    int n = 0;
    while (cas_lo_n && n < SETTLE + 100) begin @(negedge clk); n++; end
    chk(n >= SETTLE, "R1 settle length", n, SETTLE);
    chk(n <= SETTLE + 3, "R2 wake start", n, SETTLE);
    n = 0;
    while (!init_done && n < 2000) begin @(negedge clk); n++; end
    chk(pulses == WAKE, "R2 wake pulses", pulses, WAKE);
    chk(!r3_seen, "R3 early req", r3_seen, 0);
  endtask

  task automatic t_interval();
    int n = 0, p0 = pulses;
    while (!req && n < 2 * INTV) begin @(negedge clk); n++; end
    chk(n >= INTV - 2 && n <= INTV + 2, "R6 interval", n, INTV);
    chk(pulses == p0, "R7 quiet without grant", pulses, p0);
  endtask

  task automatic t_saturate();
    int n = 0, p0;
    repeat (5 * INTV + INTV / 2) @(negedge clk);
    p0 = pulses; grant = 1;
    while ((req || busy) && n < 500) begin @(negedge clk); n++; end
    grant = 0;
    chk(pulses - p0 == MAXB, "R9 saturated backlog", pulses - p0, MAXB);
    chk(n <= MAXB * (CYC_C + 2) + 4, "R8 back to back", n, MAXB * (CYC_C + 2) + 4);
    chk(!req, "R8 req released", req, 0);
  endtask

  task automatic t_drop();
    int n = 0, p0;
    while (!req && n < 2 * INTV) begin @(negedge clk); n++; end
    repeat (2 * INTV + INTV / 2) @(negedge clk);
    p0 = pulses; grant = 1; n = 0;
    while (ras_n && n < 50) begin @(negedge clk); n++; end
    grant = 0;
    repeat (20) @(negedge clk);
    chk(pulses - p0 == 1, "R11 in-flight completes", pulses - p0, 1);
    chk(req, "R11 still pending", req, 1);
    chk(ras_n && cas_lo_n && !busy, "R7 idle after drop", ras_n & cas_lo_n, 1);
    grant = 1; n = 0;
    while ((req || busy) && n < 500) begin @(negedge clk); n++; end
    grant = 0;
    chk(pulses - p0 == 3, "R8 remaining drained", pulses - p0, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerup();
    t_interval();
    t_saturate();
    t_drop();
    chk(!r3_seen, "R3 whole run", r3_seen, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule